// File: doc/BRIEF.md
# Telephone Signalling Tone Synthesizer

This block produces a digital sine-like sample stream at a fixed 3.579545 MHz sample clock for a telephone-line modem front end. One engine serves every signalling mode: the frequency-shift carriers of the 300-baud duplex standard (originate and answer channels) and the 1200-baud half-duplex standard, a steady 2100 Hz answer tone, dual-tone keypad signalling chosen by a 4-bit code, and a single-tone variant that sends just one of the two keypad frequencies.

Two phase accumulators advance by increments taken from a constant table. The table is indexed by the mode, the standard, the channel, the transmit bit and the keypad code. The upper bits of each accumulator are shaped into a signed waveform term, and the output sample is the sum of both terms. Whatever follows the sample word (filters, gain, the analog driver) lives elsewhere.

Top module: `tone_synth`

## Requirements
- R1: While txEn is low, sampleOut is 0 one cycle later and both accumulators are cleared, so after txEn rises the phase restarts at 0. After reset, sampleOut is 0.
- R2: Mode FSK (mode = 0) with modemSel = 0 and chanSel = 0 produces 980 Hz when txData = 1 and 1180 Hz when txData = 0.
- R3: Mode FSK with modemSel = 0 and chanSel = 1 produces 1650 Hz when txData = 1 and 1850 Hz when txData = 0.
- R4: Mode FSK with modemSel = 1 produces 1300 Hz when txData = 1 and 2100 Hz when txData = 0, and chanSel has no effect.
- R5: Mode answer (mode = 1) produces a steady 2100 Hz, and txData, chanSel and modemSel have no effect.
- R6: Mode dual (mode = 2) produces the low-group plus high-group pair for toneCode. 0 gives 941+1633. 1, 2, 3 give 697 with 1209, 1336, 1477. 4, 5, 6 give 770 with 1209, 1336, 1477. 7, 8, 9 give 852 with 1209, 1336, 1477. 10 gives 941+1336, 11 gives 941+1209, 12 gives 941+1477. 13, 14, 15 give 1633 with 697, 770, 852.
- R7: Mode single (mode = 3) produces one tone only: the low-group frequency of the R6 pair for toneCode 0 to 7, and the high-group frequency for toneCode 8 to 15.
- R8: Each increment equals round(f x 2^ACC_W / 3579545) with ACC_W = 24, which keeps every tone within 1% of nominal and every FSK carrier within 6 Hz.
- R9: A change of txData in FSK mode changes only the increment, so the accumulator carries on from its current phase with no reset or jump.
- R10: Each tone term uses the top 10 accumulator bits p. With x = p mod 512, the magnitude is floor(x*(512-x)/64) and the sign is negative when p >= 512, so each term lies in [-1024, 1024]. The defaults are PH_W = 10 and AMP_W = 12.
- R11: sampleOut, registered one cycle after the accumulator state it uses, is the sum of the two tone terms. Outside dual mode the second accumulator is held at 0, so it adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 3.579545 MHz nominal |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Transmit enable; low clears phase and output |
| mode | input | 2 | 0 FSK, 1 answer tone, 2 dual tone, 3 single tone |
| modemSel | input | 1 | 0 selects 300-baud carriers, 1 selects 1200-baud carriers |
| chanSel | input | 1 | 0 originate channel, 1 answer channel (300-baud only) |
| txData | input | 1 | Transmit bit in FSK mode: 1 mark, 0 space |
| toneCode | input | 4 | Keypad code for dual and single modes |
| sampleOut | output | AMP_W+1 | Signed output sample, sum of the two tone terms |

## Verification
On every cycle, the assertions check these properties: clearing forces a zero sample and zero phase, each running accumulator advances by exactly its increment, the idle second accumulator stays at zero, the output stays within twice the term peak, and a running channel never has a zero increment. The correct frequency for each mode, standard, channel and code can only be shown by the bench scenarios. They compare every sample against a model built from the table and waveform rule. They also count zero-crossing periods to confirm the tolerances, and they confirm that toggling txData in the answer-tone mode changes nothing.

// File: rtl/tone_synth_pkg.sv
package tone_synth_pkg;

  localparam longint SAMPLE_HZ = 64'd3579545;

  typedef enum logic [1:0] {
    MODE_FSK    = 2'd0,
    MODE_ANS    = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_SINGLE = 2'd3
  } synth_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic runA;
    logic runB;
  } strobe_t;

  function automatic longint phaseInc(input longint freqHz, input int accW);
    return ((freqHz << accW) + SAMPLE_HZ / 2) / SAMPLE_HZ;
  endfunction

  function automatic longint lowGroupHz(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13: return 64'd697;
      4'd4, 4'd5, 4'd6, 4'd14: return 64'd770;
      4'd7, 4'd8, 4'd9, 4'd15: return 64'd852;
      default:                 return 64'd941;
    endcase
  endfunction

  function automatic longint highGroupHz(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11: return 64'd1209;
      4'd2, 4'd5, 4'd8, 4'd10: return 64'd1336;
      4'd3, 4'd6, 4'd9, 4'd12: return 64'd1477;
      default:                 return 64'd1633;
    endcase
  endfunction

endpackage

// File: rtl/tone_synth_ctrl.sv
module tone_synth_ctrl
  import tone_synth_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic             txEn,
  input  logic [1:0]       mode,
  input  logic             modemSel,
  input  logic             chanSel,
  input  logic             txData,
  input  logic [3:0]       toneCode,
  output strobe_t          ctl,
  output logic [ACC_W-1:0] incA,
  output logic [ACC_W-1:0] incB
);

  localparam int CODES = 16;

  localparam logic [ACC_W-1:0] INC_ORIG_MARK  = ACC_W'(phaseInc(64'd980,  ACC_W));
  localparam logic [ACC_W-1:0] INC_ORIG_SPACE = ACC_W'(phaseInc(64'd1180, ACC_W));
  localparam logic [ACC_W-1:0] INC_ANS_MARK   = ACC_W'(phaseInc(64'd1650, ACC_W));
  localparam logic [ACC_W-1:0] INC_ANS_SPACE  = ACC_W'(phaseInc(64'd1850, ACC_W));
  localparam logic [ACC_W-1:0] INC_HS_MARK    = ACC_W'(phaseInc(64'd1300, ACC_W));
  localparam logic [ACC_W-1:0] INC_HS_SPACE   = ACC_W'(phaseInc(64'd2100, ACC_W));
  localparam logic [ACC_W-1:0] INC_ANSWER     = ACC_W'(phaseInc(64'd2100, ACC_W));

  logic [ACC_W-1:0] lowTab  [CODES];
  logic [ACC_W-1:0] highTab [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_tab
    assign lowTab[g]  = ACC_W'(phaseInc(lowGroupHz(4'(g)), ACC_W));
    assign highTab[g] = ACC_W'(phaseInc(highGroupHz(4'(g)), ACC_W));
  end

  synth_mode_e modeSel;
  logic [ACC_W-1:0] fskInc;
  logic [ACC_W-1:0] singleInc;

  assign modeSel = synth_mode_e'(mode);

  always_comb begin
    if (modemSel)
      fskInc = txData ? INC_HS_MARK : INC_HS_SPACE;
    else if (chanSel)
      fskInc = txData ? INC_ANS_MARK : INC_ANS_SPACE;
    else
      fskInc = txData ? INC_ORIG_MARK : INC_ORIG_SPACE;
  end

  // codes 0..7 pick the low group, 8..15 the high group
  assign singleInc = toneCode[3] ? highTab[toneCode] : lowTab[toneCode];

  always_comb begin
    ctl  = '0;
    incA = '0;
    incB = '0;
    if (!txEn) begin
      ctl.clear = 1'b1;
    end else begin
      ctl.runA = 1'b1;
      case (modeSel)
        MODE_FSK:  incA = fskInc;
        MODE_ANS:  incA = INC_ANSWER;
        MODE_DUAL: begin
          incA     = lowTab[toneCode];
          incB     = highTab[toneCode];
          ctl.runB = 1'b1;
        end
        default:   incA = singleInc;
      endcase
    end
  end

endmodule

// File: rtl/tone_synth_shape.sv
module tone_synth_shape #(
  parameter int PH_W  = 10,
  parameter int AMP_W = 12
) (
  input  logic [PH_W-1:0]         phase,
  output logic signed [AMP_W-1:0] tone
);

  localparam int HALF_W = PH_W - 1;
  localparam int PROD_W = 2 * HALF_W;
  localparam int SHIFT  = PROD_W - AMP_W;

  logic [PROD_W-1:0] xExt;
  logic [PROD_W-1:0] prod;
  logic signed [AMP_W-1:0] mag;

  assign xExt = PROD_W'(phase[HALF_W-1:0]);
  // parabola x*(H-x) peaks at H^2/4 in the middle of each half cycle
  assign prod = xExt * ((PROD_W'(1) << HALF_W) - xExt);
  assign mag  = AMP_W'(prod >> SHIFT);
  assign tone = phase[HALF_W] ? -mag : mag;

endmodule

// File: rtl/tone_synth_dp.sv
module tone_synth_dp
  import tone_synth_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int PH_W  = 10,
  parameter int AMP_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               ctl,
  input  logic [ACC_W-1:0]      incA,
  input  logic [ACC_W-1:0]      incB,
  output logic signed [AMP_W:0] sampleOut
);

  localparam int CHANS = 2;
  localparam int PEAK  = 1 << (AMP_W - 2);

  logic [ACC_W-1:0]        acc  [CHANS];
  logic [ACC_W-1:0]        inc  [CHANS];
  logic                    run  [CHANS];
  logic signed [AMP_W-1:0] tone [CHANS];

  assign inc[0] = incA;
  assign inc[1] = incB;
  assign run[0] = ctl.runA;
  assign run[1] = ctl.runB;

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       acc[c] <= '0;
      else if (run[c]) acc[c] <= acc[c] + inc[c];
      else             acc[c] <= '0;
    end

    tone_synth_shape #(.PH_W(PH_W), .AMP_W(AMP_W)) u_shape (
      .phase (acc[c][ACC_W-1 -: PH_W]),
      .tone  (tone[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sampleOut <= '0;
    else if (ctl.clear) sampleOut <= '0;
    else                sampleOut <= $signed({tone[0][AMP_W-1], tone[0]})
                                   + $signed({tone[1][AMP_W-1], tone[1]});
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (sampleOut == '0));

  // R1
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (acc[0] == '0 && acc[1] == '0));

  // R9
  phase_cont_chk: assert property (@(posedge clk) disable iff (!rstN)
    run[0] |=> (acc[0] == ACC_W'($past(acc[0]) + $past(inc[0]))));

  // R11
  idle_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run[1] |=> (acc[1] == '0));

  // R10
  amp_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleOut <= (AMP_W+1)'(2 * PEAK)) && (sampleOut >= -(AMP_W+1)'(2 * PEAK)));

  // R8
  inc_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    run[0] |-> (inc[0] != '0));

endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import tone_synth_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int PH_W  = 10,
  parameter int AMP_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  txEn,
  input  logic [1:0]            mode,
  input  logic                  modemSel,
  input  logic                  chanSel,
  input  logic                  txData,
  input  logic [3:0]            toneCode,
  output logic signed [AMP_W:0] sampleOut
);

  strobe_t          ctl;
  logic [ACC_W-1:0] incA;
  logic [ACC_W-1:0] incB;

  tone_synth_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .txEn     (txEn),
    .mode     (mode),
    .modemSel (modemSel),
    .chanSel  (chanSel),
    .txData   (txData),
    .toneCode (toneCode),
    .ctl      (ctl),
    .incA     (incA),
    .incB     (incB)
  );

  tone_synth_dp #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .incA      (incA),
    .incB      (incB),
    .sampleOut (sampleOut)
  );

endmodule

// File: tb/tone_synth_test.sv
`timescale 1ns/1ps
module tone_synth_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b0;
  logic [1:0] mode = 2'd0;
  logic modemSel = 1'b0;
  logic chanSel = 1'b0;
  logic txData = 1'b0;
  logic [3:0] toneCode = 4'd0;
  logic signed [12:0] sampleOut;

  int checks = 0;
  int errors = 0;
  longint mA = 0;
  longint mB = 0;

  always #2.5 clk = ~clk;

  tone_synth uut (
    .clk(clk), .rstN(rstN), .txEn(txEn), .mode(mode), .modemSel(modemSel),
    .chanSel(chanSel), .txData(txData), .toneCode(toneCode), .sampleOut(sampleOut)
  );

  function automatic longint incFor(input int hz);
    return ((longint'(hz) << 24) + 64'd1789772) / 64'd3579545;
  endfunction

  function automatic int termOf(input longint acc);
    int p;
    int x;
    int m;
    p = int'((acc >> 14) & 64'd1023);
    x = p % 512;
    m = (x * (512 - x)) / 64;
    return (p >= 512) ? -m : m;
  endfunction

  function automatic int lowOf(input int c);
    case (c)
      1, 2, 3, 13: return 697;
      4, 5, 6, 14: return 770;
      7, 8, 9, 15: return 852;
      default:     return 941;
    endcase
  endfunction

  function automatic int highOf(input int c);
    case (c)
      1, 4, 7, 11: return 1209;
      2, 5, 8, 10: return 1336;
      3, 6, 9, 12: return 1477;
      default:     return 1633;
    endcase
  endfunction

  task automatic setIn(input bit en, input int md, input bit ms, input bit cs,
                       input bit dt, input int code);
    txEn = en; mode = 2'(md); modemSel = ms; chanSel = cs; txData = dt;
    toneCode = 4'(code);
  endtask

  // inputs are already set at a negedge; compare n samples against the model
  task automatic runModel(input int n, input int fA, input int fB, input string req);
    int bad = 0;
    int gotV = 0;
    int expV = 0;
    for (int i = 0; i < n; i++) begin
      int e;
      e = txEn ? termOf(mA) + termOf(mB) : 0;
      if (txEn) mA = (mA + incFor(fA)) & 64'hFFFFFF; else mA = 0;
      if (txEn && fB != 0) mB = (mB + incFor(fB)) & 64'hFFFFFF; else mB = 0;
      @(negedge clk);
      if (int'(sampleOut) != e && bad == 0) begin
        gotV = int'(sampleOut);
        expV = e;
        bad = 1;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s sample actual %0d expected %0d", req, gotV, expV);
    end
  endtask

  task automatic clearModel();
    setIn(1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
    runModel(3, 0, 0, "R1_clear");
  endtask

  task automatic periodCheck(input int hz, input real tolHz, input string req);
    int crossings = 0;
    int firstAt = 0;
    int lastAt = 0;
    bit seenNeg = 1'b0;
    int limit;
    real measHz;
    limit = 6 * (3579545 / hz);
    for (int i = 0; i < limit && crossings < 5; i++) begin
      @(negedge clk);
      if (sampleOut < 0) seenNeg = 1'b1;
      else if (sampleOut > 0 && seenNeg) begin
        seenNeg = 1'b0;
        crossings++;
        if (crossings == 1) firstAt = i;
        lastAt = i;
      end
    end
    checks++;
    if (crossings < 5) begin
      errors++;
      $display("FAIL %s crossings actual %0d expected 5", req, crossings);
    end else begin
      measHz = 4.0 * 3579545.0 / real'(lastAt - firstAt);
      if (measHz < real'(hz) - tolHz || measHz > real'(hz) + tolHz) begin
        errors++;
        $display("FAIL %s frequency actual %f expected %0d", req, measHz, hz);
      end
    end
  endtask

  task automatic testReset();
    checks++;
    if (sampleOut != 0) begin
      errors++;
      $display("FAIL R1 reset sample actual %0d expected 0", sampleOut);
    end
    setIn(1'b0, 0, 1'b0, 1'b0, 1'b1, 0);
    runModel(20, 0, 0, "R1_disabled");
  endtask

  task automatic testOrig();
    clearModel();
    setIn(1'b1, 0, 1'b0, 1'b0, 1'b1, 0);
    runModel(400, 980, 0, "R2_mark");
    txData = 1'b0;
    runModel(400, 1180, 0, "R2_space_R9");
    txData = 1'b1;
    runModel(200, 980, 0, "R9_back_to_mark");
  endtask

  task automatic testAnsChan();
    clearModel();
    setIn(1'b1, 0, 1'b0, 1'b1, 1'b1, 0);
    runModel(400, 1650, 0, "R3_mark");
    txData = 1'b0;
    runModel(400, 1850, 0, "R3_space");
  endtask

  task automatic testHighSpeed();
    clearModel();
    setIn(1'b1, 0, 1'b1, 1'b0, 1'b1, 0);
    runModel(300, 1300, 0, "R4_mark");
    chanSel = 1'b1;
    runModel(300, 1300, 0, "R4_chan_ignored");
    txData = 1'b0;
    runModel(300, 2100, 0, "R4_space");
  endtask

  task automatic testAnswerTone();
    clearModel();
    setIn(1'b1, 1, 1'b0, 1'b0, 1'b0, 0);
    runModel(200, 2100, 0, "R5_tone");
    txData = 1'b1; chanSel = 1'b1; modemSel = 1'b1;
    runModel(200, 2100, 0, "R5_inputs_ignored");
  endtask

  task automatic testDual();
    clearModel();
    for (int c = 0; c < 16; c++) begin
      setIn(1'b1, 2, 1'b0, 1'b0, 1'b0, c);
      runModel(150, lowOf(c), highOf(c), $sformatf("R6_R11_code%0d", c));
    end
  endtask

  task automatic testSingle();
    for (int c = 0; c < 16; c++) begin
      setIn(1'b1, 3, 1'b0, 1'b0, 1'b0, c);
      runModel(150, (c < 8) ? lowOf(c) : highOf(c), 0,
               $sformatf("R7_R10_code%0d", c));
    end
  endtask

  task automatic testDisableMid();
    setIn(1'b1, 2, 1'b0, 1'b0, 1'b0, 5);
    runModel(100, 770, 1336, "R1_before_drop");
    txEn = 1'b0;
    runModel(5, 0, 0, "R1_dropped");
    txEn = 1'b1;
    runModel(100, 770, 1336, "R1_restart_phase");
  endtask

  task automatic testPeriods();
    setIn(1'b1, 1, 1'b0, 1'b0, 1'b0, 0);
    periodCheck(2100, 21.0, "R8_answer");
    setIn(1'b1, 0, 1'b0, 1'b0, 1'b1, 0);
    periodCheck(980, 6.0, "R8_orig_mark");
    setIn(1'b1, 3, 1'b0, 1'b0, 1'b0, 13);
    periodCheck(1633, 16.33, "R8_single_high");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrig();
    testAnsChan();
    testHighSpeed();
    testAnswerTone();
    testDual();
    testSingle();
    testDisableMid();
    testPeriods();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule